// File: doc/BRIEF.md
# Timestamp Capture Ring Buffer

This block collects time tags from up to eight sources and keeps them in a small circular store until software fetches them. A tag carries a seconds count, a 28-bit count of reference cycles, a 12-bit sub-cycle fraction and a 3-bit source number. The block attaches a 16-bit running sequence number to each tag it accepts. An accepted tag is one that arrives while capture is enabled and while its source is selected in the source mask.

Software drains the store one entry at a time. A pulse on the advance input moves the oldest stored entry into a set of readout words, and those words then hold steady until the next successful advance. The readout is split into a high and a low seconds word, a cycles word, and a combined tag word. The tag word packs the sequence number, the fraction and the source number. An empty flag tells software when nothing is left to fetch.

The incoming tag stream uses a valid/ready handshake. Ready is held high at all times, so producers never stall. When the store is full, a new tag replaces the oldest one. Purge and sequence reset are single-cycle command pulses.

Top module: `ts_ring_buffer`

## Requirements
- R1: After reset the empty flag is 1, all readout words are 0 and the next accepted tag gets sequence number 0.
- R2: A tag is stored only when ts_valid is high, cfg_enable is high and bit ts_src of cfg_chan_mask is 1. Any other tag leaves the store unchanged.
- R3: empty is 1 exactly while the store holds no entries.
- R4: An advance pulse while the store is not empty loads the oldest entry into the readout words at that clock edge. Entries come out in arrival order.
- R5: An advance pulse while the store is empty leaves every readout word unchanged.
- R6: rd_tag carries the source number in bits [2:0], a 0 in bit 3, the fraction in bits [15:4] and the sequence number in bits [31:16].
- R7: rd_sec_lo holds seconds bits [31:0], rd_sec_hi holds seconds bits [39:32], and rd_cycles holds the 28-bit cycle field.
- R8: The sequence number rises by one for each accepted tag and wraps from 65535 to 0.
- R9: After a cmd_seq_rst pulse, the next accepted tag gets sequence number 0. A tag accepted in the same cycle as the pulse also gets 0.
- R10: A tag accepted while the store is full replaces the oldest entry, so the store keeps the DEPTH newest tags.
- R11: A cmd_purge pulse empties the store, discards any tag offered in the same cycle and leaves the readout words unchanged.
- R12: ts_ready is always 1, including while the store is full.
- R13: When the store is full and a tag arrives in the same cycle as an advance, the advance returns the oldest entry and the new tag is kept as the newest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ts_valid | input | 1 | Incoming tag valid |
| ts_ready | output | 1 | Always high; the block never stalls the producer |
| ts_src | input | 3 | Source number of the incoming tag |
| ts_sec | input | 40 | Seconds of the incoming tag |
| ts_cycles | input | 28 | Reference cycle count of the incoming tag |
| ts_frac | input | 12 | Sub-cycle fraction of the incoming tag |
| cfg_enable | input | 1 | Capture enable (level) |
| cfg_chan_mask | input | 8 | One bit per source; 1 records that source |
| cmd_purge | input | 1 | Pulse: empty the store |
| cmd_seq_rst | input | 1 | Pulse: restart the sequence number at 0 |
| cmd_advance | input | 1 | Pulse: move the oldest entry into the readout words |
| empty | output | 1 | High while no entries are stored |
| rd_sec_hi | output | 8 | Readout seconds, bits [39:32] |
| rd_sec_lo | output | 32 | Readout seconds, bits [31:0] |
| rd_cycles | output | 28 | Readout cycle count |
| rd_tag | output | 32 | Readout sequence number, fraction and source number |

## Verification
The in-line assertions check four things on every cycle: the fill count never exceeds the depth, a purge always empties the store, the count stays pinned at full when a tag overwrites, and the sequence counter steps or clears as its controls dictate. They also check that a masked source or an advance on an empty store never disturbs the outputs. Some properties depend on data and order, and only the directed scenarios can show them. These are the arrival order of entries, the field positions in the tag word, which entries survive an overflow, the wrap from 65535 to 0, and the result of a full-store push and advance in the same cycle.

// File: rtl/ts_rb_pkg.sv
package ts_rb_pkg;
  localparam int SEC_W  = 40;
  localparam int CYC_W  = 28;
  localparam int FRAC_W = 12;
  localparam int SRC_W  = 3;
  localparam int SEQ_W  = 16;
  localparam int NSRC   = 1 << SRC_W;
  localparam int TAG_W  = SEQ_W + FRAC_W + 1 + SRC_W;

  typedef struct packed {
    logic [SEC_W-1:0]  sec;
    logic [CYC_W-1:0]  cyc;
    logic [FRAC_W-1:0] frac;
    logic [SRC_W-1:0]  src;
    logic [SEQ_W-1:0]  seq;
  } ts_entry_t;

  function automatic logic [TAG_W-1:0] pack_tag(ts_entry_t e);
    return {e.seq, e.frac, 1'b0, e.src};
  endfunction
endpackage

// File: rtl/ts_rb_seq.sv
module ts_rb_seq #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] seq_o
);
  logic [W-1:0] cnt;

  // value handed to an entry accepted in this cycle
  assign seq_o = clr ? '0 : cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (inc) cnt <= seq_o + 1'b1;
    else if (clr) cnt <= '0;
  end

  a_r8_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr) |=> cnt == $past(cnt) + 1'b1);
  a_r9_seq_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !inc) |=> cnt == '0);
endmodule

// File: rtl/ts_rb_store.sv
module ts_rb_store #(
  parameter int DEPTH = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 purge,
  input  logic                 push,
  input  ts_rb_pkg::ts_entry_t wr_data,
  input  logic                 adv,
  output logic                 empty,
  output ts_rb_pkg::ts_entry_t rd_q
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  ts_rb_pkg::ts_entry_t mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic full, pop, rd_step;

  function automatic logic [PTR_W-1:0] nxt(logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (count == '0);
  assign full    = (count == FULL_CNT);
  assign pop     = adv && !empty && !purge;
  // overwrite on full drags the read pointer along
  assign rd_step = pop || (push && full);

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      rd_q   <= '0;
    end else if (purge) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push)    wr_ptr <= nxt(wr_ptr);
      if (rd_step) rd_ptr <= nxt(rd_ptr);
      if (pop)     rd_q   <= mem[rd_ptr];
      if (push && !pop && !full) count <= count + 1'b1;
      else if (pop && !push)     count <= count - 1'b1;
    end
  end

  a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);
  a_r11_purge_empties: assert property (@(posedge clk) disable iff (!rst_n)
    purge |=> empty);
  a_r10_overwrite_stays_full: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !purge) |=> full);
  a_r4_pop_drops_count: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> count == $past(count) - 1'b1);
endmodule

// File: rtl/ts_ring_buffer.sv
module ts_ring_buffer #(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ts_valid,
  output logic        ts_ready,
  input  logic [2:0]  ts_src,
  input  logic [39:0] ts_sec,
  input  logic [27:0] ts_cycles,
  input  logic [11:0] ts_frac,
  input  logic        cfg_enable,
  input  logic [7:0]  cfg_chan_mask,
  input  logic        cmd_purge,
  input  logic        cmd_seq_rst,
  input  logic        cmd_advance,
  output logic        empty,
  output logic [7:0]  rd_sec_hi,
  output logic [31:0] rd_sec_lo,
  output logic [27:0] rd_cycles,
  output logic [31:0] rd_tag
);
  import ts_rb_pkg::*;

  logic [NSRC-1:0] src_hit;
  logic accept;
  logic [SEQ_W-1:0] seq_now;
  ts_entry_t in_e, out_e;

  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_src
      assign src_hit[i] = cfg_chan_mask[i] && (ts_src == SRC_W'(i));
    end
  endgenerate

  assign ts_ready = 1'b1;
  assign accept   = ts_valid && cfg_enable && (|src_hit) && !cmd_purge;

  ts_rb_seq #(.W(SEQ_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .clr(cmd_seq_rst), .inc(accept), .seq_o(seq_now)
  );

  always_comb begin
    in_e.sec  = ts_sec;
    in_e.cyc  = ts_cycles;
    in_e.frac = ts_frac;
    in_e.src  = ts_src;
    in_e.seq  = seq_now;
  end

  ts_rb_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .purge(cmd_purge), .push(accept),
    .wr_data(in_e), .adv(cmd_advance), .empty(empty), .rd_q(out_e)
  );

  assign rd_sec_hi = out_e.sec[SEC_W-1:32];
  assign rd_sec_lo = out_e.sec[31:0];
  assign rd_cycles = out_e.cyc;
  assign rd_tag    = pack_tag(out_e);

  a_r5_idle_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_advance && empty) |=> $stable(rd_tag) && $stable(rd_cycles) && $stable(rd_sec_lo));
  a_r2_masked_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_chan_mask[ts_src] && !cmd_advance && !cmd_purge) |=> $stable(empty));
  a_r11_readout_kept: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_purge |=> $stable(rd_tag) && $stable(rd_cycles));
endmodule

// File: tb/ts_ring_buffer_tb.sv
module ts_ring_buffer_tb;
  localparam int DEPTH = 8;
  logic clk = 0, rst_n = 0;
  logic ts_valid = 0, ts_ready;
  logic [2:0] ts_src = 0;
  logic [39:0] ts_sec = 0;
  logic [27:0] ts_cycles = 0;
  logic [11:0] ts_frac = 0;
  logic cfg_enable = 0;
  logic [7:0] cfg_chan_mask = 0;
  logic cmd_purge = 0, cmd_seq_rst = 0, cmd_advance = 0;
  logic empty;
  logic [7:0] rd_sec_hi;
  logic [31:0] rd_sec_lo, rd_tag;
  logic [27:0] rd_cycles;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  ts_ring_buffer #(.DEPTH(DEPTH)) u_dut (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] tag(int seq, int fr, int src);
    return {seq[15:0], fr[11:0], 1'b0, src[2:0]};
  endfunction

  task automatic push(int s, logic [39:0] sec, int cyc, int fr);
    @(negedge clk);
    ts_valid = 1; ts_src = s[2:0]; ts_sec = sec; ts_cycles = cyc[27:0]; ts_frac = fr[11:0];
    @(negedge clk);
    ts_valid = 0;
  endtask

  task automatic advance();
    @(negedge clk); cmd_advance = 1;
    @(negedge clk); cmd_advance = 0;
  endtask

  task automatic pulse_seq_rst();
    @(negedge clk); cmd_seq_rst = 1;
    @(negedge clk); cmd_seq_rst = 0;
  endtask

  task automatic t_reset();
    chk("R1 empty", empty, 1);
    chk("R1 tag", rd_tag, 0);
    chk("R1 sec", {rd_sec_hi, rd_sec_lo}, 0);
    chk("R1 cycles", rd_cycles, 0);
    chk("R12 ready", ts_ready, 1);
  endtask

  task automatic t_basic();
    cfg_enable = 1; cfg_chan_mask = 8'hFF;
    push(1, 40'h12_3456_789A, 28'hABCDEF1, 12'h5A5);
    chk("R3 not empty", empty, 0);
    push(5, 40'h00_0000_0001, 28'h0000002, 12'hFFF);
    push(7, 40'hFF_FFFF_FFFF, 28'hFFFFFFF, 12'h001);
    advance();
    chk("R7 sec_hi", rd_sec_hi, 8'h12);
    chk("R7 sec_lo", rd_sec_lo, 32'h3456789A);
    chk("R7 cycles", rd_cycles, 28'hABCDEF1);
    chk("R6 tag", rd_tag, tag(0, 12'h5A5, 1));
    advance();
    chk("R4 order", rd_cycles, 2);
    chk("R6 tag2", rd_tag, tag(1, 12'hFFF, 5));
    advance();
    chk("R8 seq", rd_tag, tag(2, 1, 7));
    chk("R7 sec_hi max", rd_sec_hi, 8'hFF);
    chk("R3 empty after drain", empty, 1);
  endtask

  task automatic t_mask();
    cfg_chan_mask = 8'b0000_0100;
    push(1, 40'd9, 9, 9);
    chk("R2 masked source", empty, 1);
    cfg_enable = 0;
    push(2, 40'd8, 8, 8);
    chk("R2 disabled", empty, 1);
    cfg_enable = 1;
    push(2, 40'd7, 7, 7);
    chk("R2 selected source", empty, 0);
    advance();
    chk("R2 entry", rd_tag, tag(3, 7, 2));
    advance();
    chk("R5 idle advance tag", rd_tag, tag(3, 7, 2));
    chk("R5 idle advance cycles", rd_cycles, 7);
    cfg_chan_mask = 8'hFF;
  endtask

  task automatic t_overflow();
    for (int i = 0; i < DEPTH + 2; i++) push(0, 40'd0, i, 0);
    for (int i = 0; i < DEPTH; i++) begin
      advance();
      chk("R10 survivor", rd_cycles, i + 2);
    end
    chk("R10 empty after", empty, 1);
  endtask

  task automatic t_purge();
    logic [31:0] tsave;
    push(0, 40'd0, 11, 0);
    push(0, 40'd0, 12, 0);
    tsave = rd_tag;
    @(negedge clk);
    cmd_purge = 1; ts_valid = 1; ts_cycles = 77;
    @(negedge clk);
    cmd_purge = 0; ts_valid = 0;
    chk("R11 empty", empty, 1);
    advance();
    chk("R11 readout kept", rd_tag, tsave);
    push(0, 40'd0, 5, 0);
    advance();
    chk("R11 same-cycle tag discarded", rd_cycles, 5);
  endtask

  task automatic t_seqrst();
    @(negedge clk);
    cmd_seq_rst = 1; ts_valid = 1; ts_src = 3; ts_cycles = 1; ts_frac = 0;
    @(negedge clk);
    cmd_seq_rst = 0; ts_valid = 0;
    push(3, 40'd0, 2, 0);
    advance();
    chk("R9 same cycle", rd_tag, tag(0, 0, 3));
    advance();
    chk("R9 next", rd_tag, tag(1, 0, 3));
    pulse_seq_rst();
    push(4, 40'd0, 3, 0);
    advance();
    chk("R9 after pulse", rd_tag, tag(0, 0, 4));
  endtask

  task automatic t_full_pushpop();
    for (int i = 0; i < DEPTH; i++) push(0, 40'd0, i, 0);
    @(negedge clk);
    ts_valid = 1; ts_cycles = 100; cmd_advance = 1;
    @(negedge clk);
    ts_valid = 0; cmd_advance = 0;
    chk("R13 oldest out", rd_cycles, 0);
    chk("R12 ready when full", ts_ready, 1);
    for (int i = 1; i < DEPTH; i++) begin
      advance();
      chk("R13 order", rd_cycles, i);
    end
    advance();
    chk("R13 newest kept", rd_cycles, 100);
    chk("R13 empty", empty, 1);
  endtask

  task automatic t_wrap();
    pulse_seq_rst();
    @(negedge clk);
    ts_valid = 1; ts_src = 6; ts_cycles = 0; ts_frac = 0;
    repeat (65537) @(posedge clk);
    @(negedge clk);
    ts_valid = 0;
    for (int k = 0; k < DEPTH; k++) begin
      advance();
      chk("R8 wrap seq", rd_tag, tag((65529 + k) & 16'hFFFF, 0, 6));
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_mask();
    t_overflow();
    t_purge();
    t_seqrst();
    t_full_pushpop();
    t_wrap();
    finish_run();
  end
endmodule